// File: doc/BRIEF.md
# Pseudo-Random Replacement Slot Picker

This block chooses which translation-cache slot to overwrite when a new mapping must be installed and no slot is marked invalid. The lowest slots can be reserved ("pinned") by a boundary value. The picker only hands out indices from the boundary up to the last slot. A 32-bit linear congruential sequence supplies the randomness. Its upper half is folded into the unpinned range by a bit-serial remainder unit.

The block remembers the last index it gave out from the random path. A draw that would repeat that index is thrown away, the generator advances once more, and the fold runs again. The caller pulses a request and samples the pin boundary in the same cycle. The caller then waits for a one-cycle valid pulse. The index stays on its output until the next result replaces it. If only the topmost slot is unpinned, that slot is returned at once and the generator does not move.

Top module: `tlb_rand_idx`

## Requirements
- R1: The generator state is 32 bits and advances as state = state * 1103515245 + 12345, truncated to 32 bits. It advances once per draw and only on a draw.
- R2: After reset the generator state is 1, the remembered index is 0, idx_o is 0, and valid_o and busy_o are 0.
- R3: With clamped boundary W and range M = N_ENTRIES - W > 1, a draw gives candidate ((state >> 16) mod M) + W. Every returned index lies in [W, N_ENTRIES-1].
- R4: A candidate equal to the remembered index is discarded and a new draw is taken, until a different index appears. The accepted index becomes the remembered index.
- R5: When M = 1, idx_o = N_ENTRIES-1 is returned in the cycle after the request. The generator does not step and the remembered index is not changed.
- R6: A boundary value of N_ENTRIES or more on wired_i is treated as N_ENTRIES-1. wired_i is sampled only in the cycle a request is accepted.
- R7: On the random path, busy_o is high from the cycle after an accepted request until the result appears. A request while busy_o is high is dropped: it is not queued, it produces no result, and it does not advance the generator.
- R8: valid_o is a one-cycle pulse, raised only while busy_o is low. idx_o holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe; taken only while busy_o is low |
| wired_i | input | $clog2(N_ENTRIES)+1 | Pinned-slot boundary, sampled with the request |
| busy_o | output | 1 | Draw and fold in progress |
| valid_o | output | 1 | One-cycle pulse: idx_o carries a new result |
| idx_o | output | $clog2(N_ENTRIES) | Selected slot index |

## Verification
A wrong generator state or a wrong remainder shows at the very first result after reset. From then on every index departs from the reference sequence, so a single request exposes it. A wrong remembered index appears only when a draw lands on the previous result. Such a fault is found within a few requests on a small range, where repeats are frequent. A request dropped or queued wrongly during busy shifts every later result by one generator step. It can also add a spurious valid pulse, which shows within one fold time of about eighteen cycles.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;
  localparam logic [31:0] LCG_MUL  = 32'd1103515245;
  localparam logic [31:0] LCG_INC  = 32'd12345;
  localparam logic [31:0] LCG_SEED = 32'd1;
  localparam int          FOLD_W   = 16;

  typedef enum logic [1:0] {
    FSM_IDLE,
    FSM_LOAD,
    FSM_WAIT
  } fsm_e;
endpackage

// File: rtl/lcg_next.sv
module lcg_next
  import tlb_rand_pkg::*;
(
  input  logic [31:0] cur_i,
  output logic [31:0] nxt_o
);
  always_comb nxt_o = cur_i * LCG_MUL + LCG_INC;
endmodule

// File: rtl/rem_serial.sv
// Restoring remainder, one dividend bit per cycle.
module rem_serial #(
  parameter int DVD_W = 16,
  parameter int DVS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             done_o,
  output logic [DVS_W-1:0] rem_o
);
  localparam int CNT_W = $clog2(DVD_W) + 1;

  logic [DVD_W-1:0] shf_q;
  logic [DVS_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             done_q;
  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   dvs_ext;

  always_comb begin
    trial   = {rem_q, shf_q[DVD_W-1]};
    dvs_ext = {1'b0, divisor_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shf_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      shf_q  <= dividend_i;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      if (trial >= dvs_ext) rem_q <= DVS_W'(trial - dvs_ext);
      else                  rem_q <= DVS_W'(trial);
      shf_q <= {shf_q[DVD_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(DVD_W - 1)) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx
  import tlb_rand_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES),
  localparam int WR_W  = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [WR_W-1:0]  wired_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [WR_W-1:0] N_W  = WR_W'(N_ENTRIES);
  localparam logic [WR_W-1:0] LAST = WR_W'(N_ENTRIES - 1);

  fsm_e             fsm_q;
  logic [31:0]      lcg_q, lcg_nxt;
  logic [WR_W-1:0]  wired_q, range_q;
  logic [WR_W-1:0]  wired_c, range_c;
  logic [IDX_W-1:0] prev_q, idx_q, cand;
  logic             valid_q;
  logic             div_done;
  logic [WR_W-1:0]  div_rem;
  logic [WR_W-1:0]  cand_w;

  lcg_next u_lcg (.cur_i(lcg_q), .nxt_o(lcg_nxt));

  rem_serial #(.DVD_W(FOLD_W), .DVS_W(WR_W)) u_rem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (fsm_q == FSM_LOAD),
    .dividend_i (lcg_q[31:16]),
    .divisor_i  (range_q),
    .done_o     (div_done),
    .rem_o      (div_rem)
  );

  always_comb begin
    wired_c = (wired_i >= N_W) ? LAST : wired_i;
    range_c = N_W - wired_c;
    cand_w  = div_rem + wired_q;
    cand    = IDX_W'(cand_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= FSM_IDLE;
      lcg_q   <= LCG_SEED;
      wired_q <= '0;
      range_q <= N_W;
      prev_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (fsm_q)
        FSM_IDLE: if (req_i) begin
          wired_q <= wired_c;
          range_q <= range_c;
          if (range_c == WR_W'(1)) begin
            idx_q   <= IDX_W'(LAST);
            valid_q <= 1'b1;
          end else begin
            lcg_q <= lcg_nxt;
            fsm_q <= FSM_LOAD;
          end
        end
        FSM_LOAD: fsm_q <= FSM_WAIT;
        FSM_WAIT: if (div_done) begin
          if (cand == prev_q) begin
            lcg_q <= lcg_nxt;
            fsm_q <= FSM_LOAD;
          end else begin
            idx_q   <= cand;
            prev_q  <= cand;
            valid_q <= 1'b1;
            fsm_q   <= FSM_IDLE;
          end
        end
        default: fsm_q <= FSM_IDLE;
      endcase
    end
  end

  assign busy_o  = (fsm_q != FSM_IDLE);
  assign valid_o = valid_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/tlb_rand_idx_chk.sv
module tlb_rand_idx_chk #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES),
  localparam int WR_W  = IDX_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             busy_o,
  input logic             valid_o,
  input logic [IDX_W-1:0] idx_o,
  input logic [WR_W-1:0]  wired_q_i,
  input logic [WR_W-1:0]  range_q_i
);
  logic [IDX_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  last_q <= '0;
    else if (valid_o && range_q_i > WR_W'(1))     last_q <= idx_o;
  end

  assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({1'b0, idx_o} >= wired_q_i && int'(idx_o) < N_ENTRIES));

  assert_no_repeat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && range_q_i > WR_W'(1)) |-> idx_o != last_q);

  assert_direct_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && range_q_i == WR_W'(1)) |-> int'(idx_o) == N_ENTRIES - 1);

  assert_busy_from_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));

  assert_valid_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);
endmodule

bind tlb_rand_idx tlb_rand_idx_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .busy_o    (busy_o),
  .valid_o   (valid_o),
  .idx_o     (idx_o),
  .wired_q_i (wired_q),
  .range_q_i (range_q)
);

// File: tb/tlb_rand_idx_test.sv
`timescale 1ns/1ps
module tlb_rand_idx_test;
  localparam int N     = 16;
  localparam int IDX_W = $clog2(N);
  localparam int WR_W  = IDX_W + 1;
  localparam int NVEC  = 14;
  // boundary per request; values >= N exercise the clamp (R6)
  localparam int WIRED_TAB [NVEC] = '{0, 0, 3, 3, 15, 7, 16, 20, 14, 14, 14, 0, 1, 12};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req = 1'b0;
  logic [WR_W-1:0]  wired = '0;
  logic             busy, valid;
  logic [IDX_W-1:0] idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  longint unsigned m_seed;
  int              m_prev;

  always #5 clk = ~clk;

  tlb_rand_idx #(.N_ENTRIES(N)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .wired_i (wired),
    .busy_o  (busy),
    .valid_o (valid),
    .idx_o   (idx)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_draw(input int w);
    int wc, m, c;
    wc = (w >= N) ? N - 1 : w;
    m  = N - wc;
    if (m == 1) return N - 1;
    do begin
      m_seed = (m_seed * 64'd1103515245 + 64'd12345) & 64'hFFFF_FFFF;
      c = int'((m_seed >> 16) % longint'(m)) + wc;
    end while (c == m_prev);
    m_prev = c;
    return c;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    req   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n  = 1'b1;
    m_seed = 1;
    m_prev = 0;
    @(negedge clk);
  endtask

  // Issue one request; returns observed index and cycles to valid.
  task automatic issue(input int w, output int got, output int lat);
    @(negedge clk);
    wired = WR_W'(w);
    req   = 1'b1;
    lat   = 0;
    got   = -1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      req = 1'b0;
      lat++;
      if (valid) begin
        got = int'(idx);
        break;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int got, lat, exp, held;
    do_reset();
    // R2 reset state
    check("R2 idx after reset", int'(idx), 0);
    check("R2 valid after reset", int'(valid), 0);
    check("R2 busy after reset", int'(busy), 0);

    // R1 R3 R4 R5 R6 table walk
    for (int v = 0; v < NVEC; v++) begin
      exp = model_draw(WIRED_TAB[v]);
      issue(WIRED_TAB[v], got, lat);
      check($sformatf("R1 R3 R4 vec %0d wired %0d", v, WIRED_TAB[v]), got, exp);
      if (WIRED_TAB[v] >= N - 1)
        check("R5 R6 direct top latency", lat, 1);
    end

    // R8 idx holds after valid pulse
    held = int'(idx);
    repeat (30) @(negedge clk);
    check("R8 valid low after pulse", int'(valid), 0);
    check("R8 idx holds", int'(idx), held);

    // R7 busy and dropped request
    @(negedge clk);
    wired = WR_W'(2);
    req   = 1'b1;
    exp   = model_draw(2);
    @(negedge clk);
    req = 1'b0;
    check("R7 busy after request", int'(busy), 1);
    @(negedge clk);
    req = 1'b1;      // must be dropped
    wired = WR_W'(15);
    @(negedge clk);
    req = 1'b0;
    got = -1;
    for (int k = 0; k < 4000; k++) begin
      if (valid) begin got = int'(idx); break; end
      @(negedge clk);
    end
    check("R7 first result unaffected", got, exp);
    held = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (valid) held++;
    end
    check("R7 no queued result", held, 0);
    exp = model_draw(2);
    issue(2, got, lat);
    check("R7 generator not stepped by dropped request", got, exp);

    // R5 direct path leaves remembered index and generator alone
    issue(15, got, lat);
    check("R5 direct top", got, N - 1);
    exp = model_draw(0);
    issue(0, got, lat);
    check("R5 sequence continues", got, exp);

    // R2 reset mid-draw restarts sequence
    @(negedge clk);
    wired = '0;
    req   = 1'b1;
    @(negedge clk);
    req = 1'b0;
    do_reset();
    check("R2 busy cleared by reset", int'(busy), 0);
    exp = model_draw(0);
    issue(0, got, lat);
    check("R2 R4 first draw after reset", got, exp);
    exp = model_draw(14);
    issue(14, got, lat);
    check("R4 two-slot range", got, exp);
    exp = model_draw(14);
    issue(14, got, lat);
    check("R4 two-slot alternates", got, exp);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule